// File: doc/BRIEF.md
# Serial Flash Erase Command Responder

This block sits on the device side of a four-wire serial link and behaves like the erase and status portion of a serial configuration flash. While the chip select is low it shifts in command bits on each rising edge of the serial clock, MSB first. It acts on four commands: set write enable, read status, erase the whole array and erase one sector. The serial clock is sampled in the system clock domain. The host must hold each serial clock level for at least two system clocks.

A status byte holds a write-enable flag and a busy flag. An accepted erase clears the write-enable flag and raises busy. A timer then counts a parameterised number of system clocks. When the count ends, the target bytes of a small on-chip array are set to 0xFF and busy drops. The status can be read at any time, including during an erase. A parallel inspection port lets the surrounding logic read any array byte.

Top module: `sfe_responder`

## Requirements
- R1: After reset the status byte reads 0x00, `miso` is 0, and array byte at address a holds a XOR 0x5A.
- R2: Command 0x06, framed by exactly 8 serial clock bits, sets the write-enable flag, which is status bit 1.
- R3: After command 0x05 the responder shifts the status byte out on `miso`, MSB first, and repeats it for every further 8 clocks while chip select stays low. Bit 0 is busy, bit 1 is write-enable, and bits 7..2 are 0. `miso` is 0 whenever chip select is high.
- R4: Command 0xC7 with exactly 8 bits and the write-enable flag set makes every array byte read 0xFF once the erase ends.
- R5: Command 0xD8 followed by a 24-bit address, with exactly 32 bits in total, makes every byte of the addressed sector read 0xFF. The sector is selected by address bits [ADDR_W-1:SECT_OFF_W]. All other sectors keep their contents.
- R6: An erase command received while the write-enable flag is 0 changes neither the array nor the status.
- R7: A command whose chip select rises after any bit count other than the one it requires (8 for 0x06 and 0xC7, 32 for 0xD8) is discarded, and the write-enable flag keeps its value.
- R8: An accepted erase starts on the chip-select rise and clears write-enable at its start. Busy stays 1 for exactly ERASE_CYCLES (whole array) or SECTOR_CYCLES (sector) clocks. The array keeps its old contents until busy falls.
- R9: A status read issued during an erase returns busy = 1 and write-enable = 0.
- R10: Write-enable and erase commands received while busy is 1 are ignored, so write-enable is still 0 when the erase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled; bits taken on its rising edge |
| mosi | input | 1 | Serial command data, MSB first |
| miso | output | 1 | Serial status data |
| rd_addr | input | ADDR_W | Inspection read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bench goes after bit-count framing. It sends write enable with nine bits, a whole-array erase with seven and with nine bits, and a sector erase with 31 bits. A design that decoded only the last eight bits would set the flag or start an erase on these. It erases without write enable, where a design missing the gate would clear the array. During a sector erase it reads status and probes the array: a design that cleared early, or left write-enable set, shows a wrong status or bytes already at 0xFF. It issues write enable while busy, where a design without the busy guard would finish the erase with write-enable set. A sector erase must leave the neighbouring sectors intact, and a repeated status read must return identical bytes.

// File: rtl/sfe_pkg.sv
// Package: command codes, status bit positions and shared types of the
// serial flash erase responder.
package sfe_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;  // set write-enable
    localparam logic [7:0] OP_RDSR = 8'h05;  // read status
    localparam logic [7:0] OP_BULK = 8'hC7;  // erase whole array
    localparam logic [7:0] OP_SECT = 8'hD8;  // erase one sector

    localparam int SHORT_CMD_BITS = 8;
    localparam int SECT_CMD_BITS  = 32;

    localparam int ST_BUSY = 0;
    localparam int ST_WEN  = 1;

    typedef enum logic {
        KIND_ALL  = 1'b0,
        KIND_SECT = 1'b1
    } erase_kind_e;

endpackage

// File: rtl/sfe_shifter.sv
// Module: sfe_shifter
// Samples the serial clock and chip select in the system clock domain,
// shifts command bits in MSB first and counts them. On the chip-select rise
// it raises a one-cycle event for a correctly framed command. It also drives
// the status byte out after a read-status opcode.
// Assumes: each sck level lasts at least two clk cycles, and mosi is stable
// around the sck rising edge.
module sfe_shifter
    import sfe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic [7:0]        status,
    output logic              miso,
    output logic              ev_wren,
    output logic              ev_bulk,
    output logic              ev_sect,
    output logic [ADDR_W-1:0] ev_addr
);

    localparam int          CNT_W   = 6;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SECT_CMD_BITS + 8);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(SHORT_CMD_BITS);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(SECT_CMD_BITS);

    logic              sck_q;
    logic              cs_q;
    logic [31:0]       shreg;
    logic [CNT_W-1:0]  cnt;
    logic              rdsr_q;
    logic [2:0]        idx;
    logic              sck_rise;
    logic              cs_rise;
    logic [7:0]        next_byte;

    assign sck_rise  = sck & ~sck_q;
    assign cs_rise   = cs_n & ~cs_q;
    assign next_byte = {shreg[6:0], mosi};

    // Edge history of the sampled serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Command shift register, saturating bit count and status output index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            rdsr_q <= 1'b0;
            idx    <= '0;
        end else if (cs_n) begin
            cnt    <= '0;
            rdsr_q <= 1'b0;
            idx    <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[30:0], mosi};
            if (cnt != CNT_SAT) begin
                cnt <= cnt + 1'b1;
            end
            if (rdsr_q) begin
                idx <= idx + 1'b1;
            end
            if (cnt == CNT_SHORT - 1'b1 && next_byte == OP_RDSR) begin
                rdsr_q <= 1'b1;
            end
        end
    end

    // Framed command decode on the chip-select rise, one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_wren <= 1'b0;
            ev_bulk <= 1'b0;
            ev_sect <= 1'b0;
            ev_addr <= '0;
        end else begin
            ev_wren <= cs_rise && cnt == CNT_SHORT && shreg[7:0] == OP_WREN;
            ev_bulk <= cs_rise && cnt == CNT_SHORT && shreg[7:0] == OP_BULK;
            ev_sect <= cs_rise && cnt == CNT_LONG  && shreg[31:24] == OP_SECT;
            ev_addr <= shreg[ADDR_W-1:0];
        end
    end

    // Status bit presented ahead of each rising sck, MSB first.
    always_comb begin
        miso = 1'b0;
        if (rdsr_q && !cs_n) begin
            miso = status[3'd7 - idx];
        end
    end

endmodule

// File: rtl/sfe_status_ctrl.sv
// Module: sfe_status_ctrl
// Holds the write-enable and busy flags and runs the self-timed erase timer.
// When the timer expires it raises a one-cycle clear request for the whole
// array or for one sector.
// Assumes: at most one command event is active per cycle.
module sfe_status_ctrl
    import sfe_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int SECT_OFF_W    = 6,
    parameter int ERASE_CYCLES  = 1000,
    parameter int SECTOR_CYCLES = 400
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_wren,
    input  logic                         ev_bulk,
    input  logic                         ev_sect,
    input  logic [ADDR_W-1:0]            ev_addr,
    output logic                         wip,
    output logic                         wel,
    output logic [7:0]                   status,
    output logic                         clr_pulse,
    output logic                         clr_all,
    output logic [ADDR_W-SECT_OFF_W-1:0] clr_sect
);

    localparam int MAX_CYC = (ERASE_CYCLES > SECTOR_CYCLES) ? ERASE_CYCLES : SECTOR_CYCLES;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] LOAD_ALL  = TMR_W'(ERASE_CYCLES - 1);
    localparam logic [TMR_W-1:0] LOAD_SECT = TMR_W'(SECTOR_CYCLES - 1);

    logic [TMR_W-1:0] timer;
    erase_kind_e      kind_q;

    // Flag updates, erase start and timer countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip      <= 1'b0;
            wel      <= 1'b0;
            timer    <= '0;
            kind_q   <= KIND_ALL;
            clr_sect <= '0;
        end else if (wip) begin
            if (timer == '0) begin
                wip <= 1'b0;
            end else begin
                timer <= timer - 1'b1;
            end
        end else begin
            if (ev_wren) begin
                wel <= 1'b1;
            end
            if ((ev_bulk || ev_sect) && wel) begin
                wip      <= 1'b1;
                wel      <= 1'b0;
                timer    <= ev_bulk ? LOAD_ALL : LOAD_SECT;
                kind_q   <= ev_bulk ? KIND_ALL : KIND_SECT;
                clr_sect <= ev_addr[ADDR_W-1:SECT_OFF_W];
            end
        end
    end

    // Status byte image and clear request.
    always_comb begin
        status          = 8'h00;
        status[ST_BUSY] = wip;
        status[ST_WEN]  = wel;
        clr_pulse       = wip && (timer == '0);
        clr_all         = (kind_q == KIND_ALL);
    end

endmodule

// File: rtl/sfe_array.sv
// Module: sfe_array
// Small byte array standing in for the flash cells. It resets to a known
// address pattern. On a clear request it sets either every byte or the bytes
// of one sector to 0xFF. Offers a combinational inspection read.
// Assumes: the depth stays small, since clears act on all bytes at once.
module sfe_array #(
    parameter int         ADDR_W     = 8,
    parameter int         SECT_OFF_W = 6,
    parameter logic [7:0] INIT_XOR   = 8'h5A
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_pulse,
    input  logic                         clr_all,
    input  logic [ADDR_W-SECT_OFF_W-1:0] clr_sect,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [7:0]                   rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SIDX_W = ADDR_W - SECT_OFF_W;

    logic [7:0] mem [DEPTH];

    function automatic logic [SIDX_W-1:0] sector_of(input int a);
        return SIDX_W'(a >> SECT_OFF_W);
    endfunction

    // Pattern load at reset, erase to all ones on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'(i) ^ INIT_XOR;
            end
        end else if (clr_pulse) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_all || sector_of(i) == clr_sect) begin
                    mem[i] <= 8'hFF;
                end
            end
        end
    end

    // Inspection read.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sfe_responder.sv
// Module: sfe_responder
// Top level of the serial flash erase responder. Ties the command shifter,
// the status and timer controller and the byte array together.
// Assumes: the host serial clock runs at most one quarter of clk.
module sfe_responder
    import sfe_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int SECT_OFF_W    = 6,
    parameter int ERASE_CYCLES  = 1000,
    parameter int SECTOR_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int SIDX_W = ADDR_W - SECT_OFF_W;

    logic              ev_wren;
    logic              ev_bulk;
    logic              ev_sect;
    logic [ADDR_W-1:0] ev_addr;
    logic              wip;
    logic              wel;
    logic [7:0]        status;
    logic              clr_pulse;
    logic              clr_all;
    logic [SIDX_W-1:0] clr_sect;

    sfe_shifter #(.ADDR_W(ADDR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .status  (status),
        .miso    (miso),
        .ev_wren (ev_wren),
        .ev_bulk (ev_bulk),
        .ev_sect (ev_sect),
        .ev_addr (ev_addr)
    );

    sfe_status_ctrl #(
        .ADDR_W        (ADDR_W),
        .SECT_OFF_W    (SECT_OFF_W),
        .ERASE_CYCLES  (ERASE_CYCLES),
        .SECTOR_CYCLES (SECTOR_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_wren   (ev_wren),
        .ev_bulk   (ev_bulk),
        .ev_sect   (ev_sect),
        .ev_addr   (ev_addr),
        .wip       (wip),
        .wel       (wel),
        .status    (status),
        .clr_pulse (clr_pulse),
        .clr_all   (clr_all),
        .clr_sect  (clr_sect)
    );

    sfe_array #(
        .ADDR_W     (ADDR_W),
        .SECT_OFF_W (SECT_OFF_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_pulse (clr_pulse),
        .clr_all   (clr_all),
        .clr_sect  (clr_sect),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sfe_responder_chk.sv
// Module: sfe_responder_chk
// Property checker for sfe_responder, attached with bind. Counts busy cycles
// to check the erase duration without deep history.
module sfe_responder_chk #(
    parameter int ERASE_CYCLES  = 1000,
    parameter int SECTOR_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic wip,
    input logic wel,
    input logic ev_bulk,
    input logic ev_sect,
    input logic clr_pulse,
    input logic clr_all
);

    int busy_cnt;

    // Busy-cycle counter for the duration check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (wip) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    a_r8_start_from_command: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(ev_bulk || ev_sect));

    a_r8_wel_cleared_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !wel);

    a_r8_end_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> $past(clr_pulse));

    a_r8_duration: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> busy_cnt == ($past(clr_all) ? ERASE_CYCLES : SECTOR_CYCLES));

    a_r10_no_wel_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !wel);

    a_r3_miso_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !miso);

endmodule

bind sfe_responder sfe_responder_chk #(
    .ERASE_CYCLES  (ERASE_CYCLES),
    .SECTOR_CYCLES (SECTOR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .miso      (miso),
    .wip       (wip),
    .wel       (wel),
    .ev_bulk   (ev_bulk),
    .ev_sect   (ev_sect),
    .clr_pulse (clr_pulse),
    .clr_all   (clr_all)
);

// File: tb/sfe_responder_bench.sv
// Directed bench for sfe_responder: one task per scenario, each checking
// its own results through the serial port and the inspection port.
module sfe_responder_bench;

    localparam int ADDR_W   = 8;
    localparam int SECT_OFF = 6;
    localparam int E_CYC    = 300;
    localparam int S_CYC    = 150;
    localparam int DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              sck = 1'b0;
    logic              mosi = 1'b0;
    logic              miso;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sfe_responder #(
        .ADDR_W        (ADDR_W),
        .SECT_OFF_W    (SECT_OFF),
        .ERASE_CYCLES  (E_CYC),
        .SECTOR_CYCLES (S_CYC)
    ) u_sfe_responder (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One framed transfer of n bits, MSB first; returns the bits seen on miso.
    task automatic xfer(input logic [39:0] dout, input int n, output logic [39:0] din);
        din = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = dout[i];
            sck  = 1'b0;
            repeat (2) @(negedge clk);
            din[i] = miso;
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [39:0] dout, input int n);
        logic [39:0] junk;
        xfer(dout, n, junk);
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [39:0] d;
        xfer(40'h0500, 16, d);
        st = d[7:0];
    endtask

    // Compare the whole array: sect = -1 none erased, -2 all, else sector index.
    task automatic check_array(input string req, input int sect);
        int bad = 0;
        logic [7:0] first_act = '0;
        logic [7:0] first_exp = '0;
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] exp;
            @(negedge clk) rd_addr = ADDR_W'(a);
            #1;
            if (sect == -2 || (sect >= 0 && (a >> SECT_OFF) == sect)) exp = 8'hFF;
            else exp = 8'(a) ^ 8'h5A;
            if (rd_data !== exp && bad == 0) begin
                first_act = rd_data;
                first_exp = exp;
            end
            if (rd_data !== exp) bad++;
        end
        n_checks++;
        if (bad != 0) begin
            n_fails++;
            $display("FAIL %s: array mismatch, first actual %02h expected %02h", req, first_act, first_exp);
        end
    endtask

    task automatic t_reset();
        logic [7:0] st;
        n_checks++;
        if (miso !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: miso actual %b expected 0", miso);
        end
        read_status(st);
        check8("R1 status after reset", st, 8'h00);
        check_array("R1 reset pattern", -1);
    endtask

    task automatic t_no_wel();
        logic [7:0] st;
        send(40'hC7, 8);
        repeat (E_CYC + 20) @(negedge clk);
        send(40'hD8000040, 32);
        repeat (S_CYC + 20) @(negedge clk);
        read_status(st);
        check8("R6 status after erase without enable", st, 8'h00);
        check_array("R6 array untouched", -1);
    endtask

    task automatic t_framing();
        logic [7:0] st;
        send(40'h006, 9);
        read_status(st);
        check8("R7 nine-bit write enable discarded", st, 8'h00);
        send(40'h06, 8);
        read_status(st);
        check8("R2 write enable sets bit 1", st, 8'h02);
        send(40'h63, 7);
        send(40'h0C7, 9);
        send(40'h6C000040, 31);
        repeat (E_CYC + 20) @(negedge clk);
        read_status(st);
        check8("R7 misframed erases keep enable", st, 8'h02);
        check_array("R7 array untouched", -1);
    endtask

    task automatic t_sector();
        logic [7:0] st;
        send(40'hD80000A3, 32);
        read_status(st);
        check8("R9 status during erase", st, 8'h01);
        @(negedge clk) rd_addr = ADDR_W'(8'h85);
        #1 check8("R8 byte unchanged while busy", rd_data, 8'h85 ^ 8'h5A);
        send(40'h06, 8);
        repeat (S_CYC + 20) @(negedge clk);
        read_status(st);
        check8("R10 enable ignored while busy", st, 8'h00);
        check_array("R5 only sector 2 erased", 2);
    endtask

    task automatic t_bulk();
        logic [7:0] st;
        send(40'h06, 8);
        send(40'hC7, 8);
        read_status(st);
        check8("R8 busy after accepted erase", st, 8'h01);
        repeat (E_CYC + 20) @(negedge clk);
        read_status(st);
        check8("R8 idle after erase", st, 8'h00);
        check_array("R4 whole array erased", -2);
    endtask

    task automatic t_repeat_status();
        logic [39:0] d;
        send(40'h06, 8);
        xfer(40'h050000, 24, d);
        check8("R3 first status byte", d[15:8], 8'h02);
        check8("R3 repeated status byte", d[7:0], 8'h02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_wel();
        t_framing();
        t_sector();
        t_bulk();
        t_repeat_status();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule